// File: doc/BRIEF.md
# Per-Channel Output Fault Diagnostic Controller

This block supervises the outputs of a multi-channel line driver (two channels by default). Each channel presents five synchronous fault-detect inputs: short to supply, short to ground, overcurrent, excessive offset and open load. A fault is captured into that channel's fault register only while the global diagnostic-enable bit and the matching bit of the channel's mask register are both set. Captured bits stay set until software reads the fault register. Any captured fault sets a status flag bit and pulls an active-low flag pin.

A short to supply on an enabled channel always switches that channel off, with its output enable low (high impedance). Neither the mask nor the diagnostic bit can prevent this. An off channel is turned back on by a one-shot retry bit in the control register. In stand-alone mode it is also turned back on by a timer that fires every 500 ms, derived from the clock-frequency parameter, for as long as the channel stays off. In stand-alone mode the flag pin gives a one-cycle low pulse at each shutdown and is not held low for latched faults. Software access uses a simple synchronous register port with a combinational read path.

Top module: `chan_fault_diag`

## Requirements
- R1: After reset, every register reads 0x00, every channel enable output is 1 and the flag pin is 1.
- R2: Channel c's mask register is at address 0x07+c (so the right channel is at 0x08). Its writable bits are D7 short-to-supply, D6 short-to-ground, D5 overcurrent, D3 excessive offset and D2 open load. D4, D1 and D0 always read 0.
- R3: Channel c's fault register is at address 0x03+c and uses the same bit positions as the mask. Raw input bit k of channel c (input index c*5+k, with k = 0 supply, 1 ground, 2 overcurrent, 3 offset, 4 open) sets its fault bit at the next clock edge only when control bit 0 (diagnostic enable) and the matching mask bit are both 1.
- R4: A read of channel c's fault register clears that register at the clock edge of the read. A fault input that is active in that same cycle is captured anyway, so setting wins over clearing.
- R5: In normal mode (control bit 1 = 0), bit 0 of the status register (address 0x01) and the inverted flag pin are both 1 exactly while any captured fault bit is set in any channel.
- R6: A short-to-supply input on an enabled channel drives that channel's enable output low after the next clock edge, whatever the mask and diagnostic bits are. Other channels are not affected.
- R7: Writing 1 to control bit 2+c turns channel c back on after that write's clock edge. The retry bits always read 0. If the short is still present, the channel turns off again one edge later and the fault bit is captured again.
- R8: In stand-alone mode (control bit 1 = 1), a channel that is off turns itself back on after RETRY_CYC = CLK_HZ/1000*RETRY_MS clock cycles off. This repeats while the fault persists.
- R9: In stand-alone mode the flag pin is low for exactly the one cycle that follows each shutdown edge and is high otherwise, even while fault bits are latched.
- R10: Unmapped addresses read 0x00. Writes to the status and fault registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears a fault register at the edge) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as rd_en_i |
| fault_raw_i | input | N_CH*5 | Raw synchronous fault inputs, channel c at [c*5 +: 5] |
| ch_en_o | output | N_CH | Channel output enable, 0 means high impedance |
| flag_n_o | output | 1 | Active-low fault flag pin |

## Verification
The assertions assume that the raw fault inputs are already synchronous to the clock and that a read strobe is never given together with a write strobe. The stimulus drives every input half a period away from the rising edge and uses separate write and read tasks, so neither assumption is ever violated. Fault inputs are either single-cycle pulses or held across a known number of edges, so every capture, clear and shutdown can be predicted to the exact cycle. The stand-alone timer is shortened through the clock-frequency parameter, which lets the bench reach the re-enable instant and the edge just before it.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
   localparam int N_FLT   = 5;
   localparam int DATA_W  = 8;

   // register addresses
   localparam int A_CTRL  = 'h00;
   localparam int A_STAT  = 'h01;
   localparam int A_FLT0  = 'h03;
   localparam int A_MSK0  = 'h07;

   // control bit positions
   localparam int CTL_DIAG   = 0;
   localparam int CTL_SOLO   = 1;
   localparam int CTL_RETRY0 = 2;

   // fault index inside one channel
   typedef enum int {
      FT_SUPPLY  = 0,
      FT_GROUND  = 1,
      FT_OVERCUR = 2,
      FT_OFFSET  = 3,
      FT_OPEN    = 4
   } fault_e;

   // fault vector -> register byte layout
   function automatic logic [DATA_W-1:0] to_reg(input logic [N_FLT-1:0] f);
      return {f[FT_SUPPLY], f[FT_GROUND], f[FT_OVERCUR], 1'b0,
              f[FT_OFFSET], f[FT_OPEN], 2'b00};
   endfunction

   // register byte layout -> fault vector
   function automatic logic [N_FLT-1:0] from_reg(input logic [DATA_W-1:0] r);
      return {r[2], r[3], r[5], r[6], r[7]};
   endfunction
endpackage

// File: rtl/cfd_retry_timer.sv
module cfd_retry_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 2) begin : g_bad
         $error("cfd_retry_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end   = (cnt_q == CW'(LIMIT - 1));
   assign expire_o = run_i & at_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (!run_i || at_end) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   // R8
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(LIMIT - 1));

   // R8
   idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> cnt_q == '0);
endmodule

// File: rtl/cfd_channel.sv
module cfd_channel
   import cfd_pkg::*;
#(
   parameter int RETRY_CYC = 1000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_FLT-1:0]  raw_i,
   input  logic              diag_en_i,
   input  logic              solo_i,
   input  logic              mask_we_i,
   input  logic [N_FLT-1:0]  mask_wd_i,
   input  logic              rd_clr_i,
   input  logic              retry_i,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] flt_o,
   output logic              any_flt_o,
   output logic              en_o,
   output logic              shut_evt_o
);
   logic [N_FLT-1:0] mask_q;
   logic [N_FLT-1:0] lat_q;
   logic [N_FLT-1:0] lat_d;
   logic [N_FLT-1:0] gated;
   logic             en_q;
   logic             en_d;
   logic             auto_fire;

   assign gated = raw_i & mask_q & {N_FLT{diag_en_i}};
   assign lat_d = (rd_clr_i ? '0 : lat_q) | gated;

   // shutdown is never masked
   assign shut_evt_o = en_q & raw_i[FT_SUPPLY];

   cfd_retry_timer #(.LIMIT(RETRY_CYC)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (solo_i & ~en_q),
      .expire_o (auto_fire)
   );

   always_comb begin
      en_d = en_q;
      if (shut_evt_o)                       en_d = 1'b0;
      else if (!en_q && (retry_i || auto_fire)) en_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
         lat_q  <= '0;
         en_q   <= 1'b1;
      end else begin
         if (mask_we_i) mask_q <= mask_wd_i;
         lat_q <= lat_d;
         en_q  <= en_d;
      end
   end

   assign mask_o    = to_reg(mask_q);
   assign flt_o     = to_reg(lat_q);
   assign any_flt_o = |lat_q;
   assign en_o      = en_q;

   // R6
   shut_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o && raw_i[FT_SUPPLY] |=> !en_o);

   // R7
   retry_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_o && retry_i |=> en_o);

   // R4
   lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_clr_i |=> (lat_q & $past(lat_q)) == $past(lat_q));

   // R3
   no_diag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !diag_en_i |=> (lat_q & ~$past(lat_q)) == '0);

   // R4
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_clr_i && diag_en_i |=> lat_q == $past(raw_i & mask_q));
endmodule

// File: rtl/chan_fault_diag.sv
module chan_fault_diag
   import cfd_pkg::*;
#(
   parameter int N_CH     = 2,
   parameter int ADDR_W   = 4,
   parameter int CLK_HZ   = 10_000_000,
   parameter int RETRY_MS = 500
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_en_i,
   input  logic                    rd_en_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [DATA_W-1:0]       rdata_o,
   input  logic [N_CH*N_FLT-1:0]   fault_raw_i,
   output logic [N_CH-1:0]         ch_en_o,
   output logic                    flag_n_o
);
   localparam int RETRY_CYC = (CLK_HZ / 1000) * RETRY_MS;
   localparam int CTL_W     = CTL_RETRY0;

   generate
      if (N_CH < 1 || N_CH > 4) begin : g_bad_nch
         $error("chan_fault_diag: N_CH must be 1..4");
      end
      if (ADDR_W < 4) begin : g_bad_aw
         $error("chan_fault_diag: ADDR_W must be at least 4");
      end
      if (RETRY_CYC < 2) begin : g_bad_retry
         $error("chan_fault_diag: retry interval too short");
      end
   endgenerate

   logic [CTL_W-1:0]   ctrl_q;
   logic               pulse_q;
   logic [DATA_W-1:0]  mask_rd [N_CH];
   logic [DATA_W-1:0]  flt_rd  [N_CH];
   logic [N_CH-1:0]    any_flt;
   logic [N_CH-1:0]    shut_evt;
   logic               ctrl_wr;
   logic               any_lat;
   logic               unused_wbits;

   assign ctrl_wr      = wr_en_i && (int'(addr_i) == A_CTRL);
   assign unused_wbits = ^wdata_i;

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         logic mask_we;
         logic rd_clr;
         assign mask_we = wr_en_i && (int'(addr_i) == A_MSK0 + c);
         assign rd_clr  = rd_en_i && (int'(addr_i) == A_FLT0 + c);

         cfd_channel #(.RETRY_CYC(RETRY_CYC)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .raw_i      (fault_raw_i[c*N_FLT +: N_FLT]),
            .diag_en_i  (ctrl_q[CTL_DIAG]),
            .solo_i     (ctrl_q[CTL_SOLO]),
            .mask_we_i  (mask_we),
            .mask_wd_i  (from_reg(wdata_i)),
            .rd_clr_i   (rd_clr),
            .retry_i    (ctrl_wr & wdata_i[CTL_RETRY0 + c]),
            .mask_o     (mask_rd[c]),
            .flt_o      (flt_rd[c]),
            .any_flt_o  (any_flt[c]),
            .en_o       (ch_en_o[c]),
            .shut_evt_o (shut_evt[c])
         );
      end
   endgenerate

   assign any_lat = |any_flt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         pulse_q <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= wdata_i[CTL_W-1:0];
         pulse_q <= |shut_evt;
      end
   end

   assign flag_n_o = ctrl_q[CTL_SOLO] ? ~pulse_q : ~any_lat;

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         if (int'(addr_i) == A_CTRL) rdata_o = DATA_W'(ctrl_q);
         if (int'(addr_i) == A_STAT) rdata_o = DATA_W'(any_lat);
         for (int c = 0; c < N_CH; c++) begin
            if (int'(addr_i) == A_FLT0 + c) rdata_o = flt_rd[c];
            if (int'(addr_i) == A_MSK0 + c) rdata_o = mask_rd[c];
         end
      end
   end

   // R9
   solo_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_q[CTL_SOLO] && $stable(ctrl_q) && shut_evt == '0 |=> flag_n_o);

   // R10
   stat_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && int'(addr_i) != A_CTRL |=> $stable(ctrl_q));
endmodule

// File: tb/chan_fault_diag_tb_top.sv
module chan_fault_diag_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 2;
   localparam int TB_HZ      = 2000;
   localparam int TB_MS      = 500;
   localparam int LIM        = TB_HZ / 1000 * TB_MS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             rd_en = 1'b0;
   logic [3:0]       addr = '0;
   logic [7:0]       wdata = '0;
   logic [7:0]       rdata;
   logic [NCH*5-1:0] raw = '0;
   logic [NCH-1:0]   ch_en;
   logic             flag_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_fault_diag #(.N_CH(NCH), .ADDR_W(4), .CLK_HZ(TB_HZ), .RETRY_MS(TB_MS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .fault_raw_i(raw), .ch_en_o(ch_en), .flag_n_o(flag_n));

   typedef struct packed {
      logic       ch;
      logic [4:0] raw;
      logic [7:0] msk;
      logic       diag;
      logic [7:0] exp;
   } vec_t;

   // raw index: 0 supply, 1 ground, 2 overcurrent, 3 offset, 4 open
   localparam vec_t VECS [9] = '{
      '{1'b0, 5'b11111, 8'hFF, 1'b1, 8'hEC},
      '{1'b1, 5'b11111, 8'hFF, 1'b0, 8'h00},
      '{1'b1, 5'b00010, 8'h40, 1'b1, 8'h40},
      '{1'b1, 5'b00010, 8'hBF, 1'b1, 8'h00},
      '{1'b0, 5'b10000, 8'h04, 1'b1, 8'h04},
      '{1'b0, 5'b01100, 8'h28, 1'b1, 8'h28},
      '{1'b1, 5'b00001, 8'h80, 1'b1, 8'h80},
      '{1'b0, 5'b01100, 8'h20, 1'b1, 8'h20},
      '{1'b1, 5'b10101, 8'h24, 1'b1, 8'h24}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(1);

      // R1 reset state
      chk("R1 ch_en", 8'(ch_en), 8'h03);
      chk("R1 flag_n", 8'(flag_n), 8'h01);
      foreach (d[i]) ;
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), d);
         chk("R1 reg", d, 8'h00);
      end

      // R2 mask layout
      wr(4'h8, 8'hFF); rd(4'h8, d); chk("R2 right mask", d, 8'hEC);
      wr(4'h7, 8'h13); rd(4'h7, d); chk("R2 reserved bits", d, 8'h00);

      // R10 unmapped and read-only
      rd(4'hF, d); chk("R10 unmapped", d, 8'h00);
      wr(4'h1, 8'hFF); rd(4'h1, d); chk("R10 status ro", d, 8'h00);
      wr(4'h3, 8'hFF); rd(4'h3, d); chk("R10 fault ro", d, 8'h00);

      // R3/R4/R5 vector table
      foreach (VECS[v]) begin
         vec_t t = VECS[v];
         wr(4'h7 + 4'(t.ch), t.msk);
         wr(4'h0, {7'b0, t.diag});
         @(negedge clk);
         raw[t.ch*5 +: 5] = t.raw;
         @(negedge clk);
         raw = '0;
         chk("R5 flag_n", 8'(flag_n), 8'(t.exp == 8'h00));
         rd(4'h1, d); chk("R5 status", d, 8'(t.exp != 8'h00));
         rd(4'h3 + 4'(t.ch), d); chk("R3 capture", d, t.exp);
         rd(4'h3 + 4'(t.ch), d); chk("R4 clear", d, 8'h00);
         wr(4'h0, {4'b0, 2'b11, 1'b0, t.diag});
         chk("R7 restore", 8'(ch_en), 8'h03);
      end

      // R4 set wins over clear-on-read
      wr(4'h7, 8'h40);
      wr(4'h0, 8'h01);
      @(negedge clk); raw[1] = 1'b1;
      @(negedge clk);
      rd(4'h3, d); chk("R4 first read", d, 8'h40);
      rd(4'h3, d); chk("R4 set wins", d, 8'h40);
      raw = '0;
      rd(4'h3, d); chk("R4 last capture", d, 8'h40);
      rd(4'h3, d); chk("R4 cleared", d, 8'h00);

      // R6 unmaskable shutdown
      wr(4'h7, 8'h00);
      wr(4'h0, 8'h00);
      @(negedge clk); raw[0] = 1'b1;
      @(negedge clk); raw = '0;
      chk("R6 ch0 off", 8'(ch_en), 8'h02);
      chk("R6 flag idle", 8'(flag_n), 8'h01);
      rd(4'h3, d); chk("R6 no capture", d, 8'h00);
      wr(4'h0, 8'h04);
      chk("R7 retry ch0", 8'(ch_en), 8'h03);

      // R7 retry while short persists
      wr(4'h8, 8'h80);
      wr(4'h0, 8'h01);
      @(negedge clk); raw[5] = 1'b1;
      @(negedge clk);
      chk("R6 ch1 off", 8'(ch_en), 8'h01);
      rd(4'h4, d);
      wr(4'h0, 8'h09);
      chk("R7 retry on", 8'(ch_en), 8'h03);
      @(negedge clk);
      chk("R7 off again", 8'(ch_en), 8'h01);
      rd(4'h0, d); chk("R7 retry reads 0", d, 8'h01);
      raw = '0;
      rd(4'h4, d); chk("R7 recaptured", d, 8'h80);
      wr(4'h0, 8'h09);
      chk("R7 recovered", 8'(ch_en), 8'h03);

      // R8/R9 stand-alone, single short
      wr(4'h7, 8'h80);
      wr(4'h0, 8'h03);
      raw[0] = 1'b1;
      wait_neg(1);
      raw = '0;
      chk("R9 pulse low", 8'(flag_n), 8'h00);
      chk("R8 off", 8'(ch_en), 8'h02);
      wait_neg(1);
      chk("R9 pulse ends", 8'(flag_n), 8'h01);
      wait_neg(LIM - 2);
      chk("R8 still off", 8'(ch_en), 8'h02);
      wait_neg(1);
      chk("R8 auto on", 8'(ch_en), 8'h03);

      // R8/R9 stand-alone, persistent short
      raw[0] = 1'b1;
      wait_neg(1);
      chk("R8 persist off", 8'(ch_en), 8'h02);
      wait_neg(LIM - 1);
      chk("R8 before retry", 8'(ch_en), 8'h02);
      wait_neg(1);
      chk("R8 retry fires", 8'(ch_en), 8'h03);
      wait_neg(1);
      chk("R8 reshut", 8'(ch_en), 8'h02);
      chk("R9 second pulse", 8'(flag_n), 8'h00);
      wait_neg(LIM - 1);
      chk("R8 second wait", 8'(ch_en), 8'h02);
      wait_neg(1);
      chk("R8 second retry", 8'(ch_en), 8'h03);
      raw = '0;
      wait_neg(2);
      chk("R8 stays on", 8'(ch_en), 8'h03);
      rd(4'h3, d); chk("R9 latched yet flag high", d, 8'h80);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule